// File: doc/BRIEF.md
# Auxiliary interrupt latch controller

This block gathers board-level interrupt events into sticky latches and drives two requests to a local processor: a maskable request that follows the dual-port access latch, and a non-maskable request raised by any of four auxiliary latches (system failure, power failure, abort button, watchdog). Each latch is armed and cleared through a bit of a control register. The events stay latched until software clears the arming bit, so the handler can read status bytes to find the cause.

A second write port holds a global non-maskable mask whose polarity is inverted: writing data bit 7 as 0 opens the path and writing it as 1 closes it. An internal watchdog counter, restarted by a service strobe, times out after a parameterized number of clock cycles (`WD_CYCLES`). All register writes and latch updates take effect on the rising clock edge, and the status bytes and request outputs follow the latch registers combinationally.

Top module: `aux_irq_ctrl`

## Requirements
- R1: After reset, every latch is clear, `status1` reads 0x00, `status2` reads 0x80, `auxIntStat` reads 0x00, `irqOut` and `nmiOut` are 0, the control register is 0x00 and the non-maskable mask is in the disabled state.
- R2: A clock edge with `dpRdStb` high, `dpAddr` below `DP_IRQ_SPAN` (16) and `dpIrqJumper` high sets the dual-port latch. From that edge `auxIntStat` bit 0 and `irqOut` read 1.
- R3: A dual-port strobe with an address of 16 or above, or any strobe while `dpIrqJumper` is 0, leaves the dual-port latch unchanged.
- R4: A control write with data bit 7 equal to 0 clears the dual-port latch at that edge and wins over a set in the same cycle. A control write with bit 7 equal to 1 leaves the latch as it is.
- R5: While control bit 4 is 1, an edge with `acFailEvt`, `sysFailEvt` or `abortEvt` high sets that event's own latch, reported in `status1` bit 1, bit 2 or bit 3 respectively (1 = set). While bit 4 is 0, the events set nothing.
- R6: A control write with bit 4 equal to 0 clears all three failure latches at that edge.
- R7: While control bit 0 is 1, the watchdog latch sets on the `WD_CYCLES`-th clock edge after the last restart. A restart is an edge with `wdService` high, or an edge while control bit 0 is 0.
- R8: `status2` bit 7 reads 0 while the watchdog latch is set and 1 while it is clear. A control write with bit 0 equal to 0 clears the latch at that edge. Bits 6..0 of `status2` read 0.
- R9: A write to the mask port with data bit 7 equal to 0 enables `nmiOut`, and a write with bit 7 equal to 1 disables it. `nmiOut` is 1 exactly when the mask is enabled and a failure or watchdog latch is set. The dual-port latch never drives `nmiOut`.

Control register bits: 0 = watchdog enable, 4 = failure-event enable, 7 = dual-port keep (0 clears). The other bits are stored and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| dpRdStb | input | 1 | One-cycle strobe: the other bus master read the dual-port memory |
| dpAddr | input | DP_ADDR_W | Byte address of that read |
| dpIrqJumper | input | 1 | Static enable of the dual-port interrupt |
| sysFailEvt | input | 1 | Synchronized system-failure event |
| acFailEvt | input | 1 | Synchronized power-failure event |
| abortEvt | input | 1 | Synchronized abort-button event |
| wdService | input | 1 | Watchdog restart strobe |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control register write data |
| nmiWrEn | input | 1 | Non-maskable mask write strobe |
| nmiWrData | input | 8 | Mask write data, bit 7 = 1 disables |
| status1 | output | 8 | Failure latch status byte |
| status2 | output | 8 | Watchdog status byte, bit 7 inverted |
| auxIntStat | output | 8 | Auxiliary interrupt byte, bit 0 = dual-port pending |
| irqOut | output | 1 | Maskable interrupt request |
| nmiOut | output | 1 | Non-maskable interrupt request |

## Verification
The dual-port path is driven with addresses at 0, 15 and 16 and with the jumper both on and off, which separates the address window bound from the enable. Each failure event is pulsed alone with the enable bit both clear and set, so a swapped status bit or a missing enable shows up. The watchdog is run once without service and once with a mid-period service, with the latch sampled on the edge before and on the edge of expiry, which exposes off-by-one counts and a missing restart. The mask is toggled while only the dual-port latch is set and while a failure latch is set, which separates the mask polarity from the latch selection.

// File: rtl/aux_irq_pkg.sv
package aux_irq_pkg;
  localparam int CTRL_WD_BIT   = 0;
  localparam int CTRL_FAIL_BIT = 4;
  localparam int CTRL_DP_BIT   = 7;
  localparam int NMI_MASK_BIT  = 7;
  localparam int NUM_FAIL      = 3;  // index 0 ac, 1 sys, 2 abort

  typedef struct packed {
    logic                dpSet;
    logic                dpClr;
    logic [NUM_FAIL-1:0] failSet;
    logic                failClr;
    logic                wdRun;
    logic                wdClr;
  } latchCtl_t;
endpackage

// File: rtl/aux_irq_regs.sv
module aux_irq_regs
  import aux_irq_pkg::*;
#(
  parameter int DP_ADDR_W   = 12,
  parameter int DP_IRQ_SPAN = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dpRdStb,
  input  logic [DP_ADDR_W-1:0] dpAddr,
  input  logic                 dpIrqJumper,
  input  logic [NUM_FAIL-1:0]  failEvt,
  input  logic                 ctrlWrEn,
  input  logic [7:0]           ctrlWrData,
  input  logic                 nmiWrEn,
  input  logic [7:0]           nmiWrData,
  output latchCtl_t            ctl,
  output logic                 nmiEnable
);
  localparam logic [DP_ADDR_W-1:0] SPAN = DP_ADDR_W'(DP_IRQ_SPAN);

  logic [7:0] ctrlReg;
  logic       nmiMaskN;  // 1 = disabled
  logic       dpHit;
  logic       failOff;
  logic       wdOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= 8'h00;
      nmiMaskN <= 1'b1;
    end else begin
      if (ctrlWrEn) ctrlReg  <= ctrlWrData;
      if (nmiWrEn)  nmiMaskN <= nmiWrData[NMI_MASK_BIT];
    end
  end

  always_comb begin
    dpHit   = dpRdStb && dpIrqJumper && (dpAddr < SPAN);
    failOff = !ctrlReg[CTRL_FAIL_BIT] || (ctrlWrEn && !ctrlWrData[CTRL_FAIL_BIT]);
    wdOff   = !ctrlReg[CTRL_WD_BIT]   || (ctrlWrEn && !ctrlWrData[CTRL_WD_BIT]);

    ctl.dpClr   = ctrlWrEn && !ctrlWrData[CTRL_DP_BIT];
    ctl.dpSet   = dpHit && !ctl.dpClr;
    ctl.failClr = failOff;
    ctl.failSet = failOff ? '0 : failEvt;
    ctl.wdClr   = wdOff;
    ctl.wdRun   = !wdOff;
    nmiEnable   = !nmiMaskN;
  end
endmodule

// File: rtl/aux_irq_latches.sv
module aux_irq_latches
  import aux_irq_pkg::*;
#(
  parameter int WD_CYCLES = 7_500_000
) (
  input  logic                clk,
  input  logic                rstN,
  input  latchCtl_t           ctl,
  input  logic                wdService,
  output logic                dpLatch,
  output logic [NUM_FAIL-1:0] failLatch,
  output logic                wdLatch
);
  localparam int CNT_W = $clog2(WD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_CYCLES - 1);

  logic [CNT_W-1:0] wdCnt;

  always_ff @(posedge clk) begin
    if (!rstN)          dpLatch <= 1'b0;
    else if (ctl.dpClr) dpLatch <= 1'b0;
    else if (ctl.dpSet) dpLatch <= 1'b1;
  end

  for (genvar i = 0; i < NUM_FAIL; i++) begin : gFail
    always_ff @(posedge clk) begin
      if (!rstN)               failLatch[i] <= 1'b0;
      else if (ctl.failClr)    failLatch[i] <= 1'b0;
      else if (ctl.failSet[i]) failLatch[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt   <= '0;
      wdLatch <= 1'b0;
    end else if (ctl.wdClr) begin
      wdCnt   <= '0;
      wdLatch <= 1'b0;
    end else if (wdService) begin
      wdCnt   <= '0;
    end else if (ctl.wdRun && !wdLatch) begin
      if (wdCnt == LAST) wdLatch <= 1'b1;
      else               wdCnt   <= wdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/aux_irq_ctrl.sv
module aux_irq_ctrl
  import aux_irq_pkg::*;
#(
  parameter int DP_ADDR_W   = 12,
  parameter int DP_IRQ_SPAN = 16,
  parameter int WD_CYCLES   = 7_500_000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dpRdStb,
  input  logic [DP_ADDR_W-1:0] dpAddr,
  input  logic                 dpIrqJumper,
  input  logic                 sysFailEvt,
  input  logic                 acFailEvt,
  input  logic                 abortEvt,
  input  logic                 wdService,
  input  logic                 ctrlWrEn,
  input  logic [7:0]           ctrlWrData,
  input  logic                 nmiWrEn,
  input  logic [7:0]           nmiWrData,
  output logic [7:0]           status1,
  output logic [7:0]           status2,
  output logic [7:0]           auxIntStat,
  output logic                 irqOut,
  output logic                 nmiOut
);
  latchCtl_t           ctl;
  logic                nmiEnable;
  logic                dpLatch;
  logic [NUM_FAIL-1:0] failLatch;
  logic                wdLatch;

  aux_irq_regs #(.DP_ADDR_W(DP_ADDR_W), .DP_IRQ_SPAN(DP_IRQ_SPAN)) uRegs (
    .clk(clk), .rstN(rstN), .dpRdStb(dpRdStb), .dpAddr(dpAddr),
    .dpIrqJumper(dpIrqJumper), .failEvt({abortEvt, sysFailEvt, acFailEvt}),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .nmiWrEn(nmiWrEn),
    .nmiWrData(nmiWrData), .ctl(ctl), .nmiEnable(nmiEnable)
  );

  aux_irq_latches #(.WD_CYCLES(WD_CYCLES)) uLatches (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wdService(wdService),
    .dpLatch(dpLatch), .failLatch(failLatch), .wdLatch(wdLatch)
  );

  assign status1    = {4'b0000, failLatch, 1'b0};
  assign status2    = {!wdLatch, 7'b0000000};
  assign auxIntStat = {7'b0000000, dpLatch};
  assign irqOut     = dpLatch;
  assign nmiOut     = nmiEnable && ((|failLatch) || wdLatch);
endmodule

// File: rtl/aux_irq_ctrl_chk.sv
module aux_irq_ctrl_chk #(
  parameter int DP_ADDR_W   = 12,
  parameter int DP_IRQ_SPAN = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dpRdStb,
  input logic [DP_ADDR_W-1:0] dpAddr,
  input logic                 dpIrqJumper,
  input logic                 ctrlWrEn,
  input logic [7:0]           ctrlWrData,
  input logic                 nmiWrEn,
  input logic [7:0]           nmiWrData,
  input logic [7:0]           status1,
  input logic [7:0]           auxIntStat,
  input logic                 nmiOut
);
  // R2
  dp_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpRdStb && dpIrqJumper && (dpAddr < DP_ADDR_W'(DP_IRQ_SPAN)) && !(ctrlWrEn && !ctrlWrData[7]))
    |=> auxIntStat[0]);

  // R3
  dp_jumper_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dpIrqJumper && !auxIntStat[0]) |=> !auxIntStat[0]);

  // R4
  dp_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !ctrlWrData[7]) |=> !auxIntStat[0]);

  // R6
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !ctrlWrData[4]) |=> (status1[3:1] == 3'b000));

  // R9
  nmi_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nmiWrEn && nmiWrData[7]) |=> !nmiOut);
endmodule

bind aux_irq_ctrl aux_irq_ctrl_chk #(.DP_ADDR_W(DP_ADDR_W), .DP_IRQ_SPAN(DP_IRQ_SPAN)) uChk (
  .clk(clk), .rstN(rstN), .dpRdStb(dpRdStb), .dpAddr(dpAddr),
  .dpIrqJumper(dpIrqJumper), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
  .nmiWrEn(nmiWrEn), .nmiWrData(nmiWrData), .status1(status1),
  .auxIntStat(auxIntStat), .nmiOut(nmiOut)
);

// File: tb/tb_aux_irq_ctrl.sv
`timescale 1ns/1ps
module tb_aux_irq_ctrl;
  localparam int AW = 12;
  localparam int WD = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dpRdStb = 0, dpIrqJumper = 1;
  logic [AW-1:0] dpAddr = '0;
  logic sysFailEvt = 0, acFailEvt = 0, abortEvt = 0, wdService = 0;
  logic ctrlWrEn = 0, nmiWrEn = 0;
  logic [7:0] ctrlWrData = 0, nmiWrData = 0;
  logic [7:0] status1, status2, auxIntStat;
  logic irqOut, nmiOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  aux_irq_ctrl #(.DP_ADDR_W(AW), .DP_IRQ_SPAN(16), .WD_CYCLES(WD)) dut (
    .clk(clk), .rstN(rstN), .dpRdStb(dpRdStb), .dpAddr(dpAddr),
    .dpIrqJumper(dpIrqJumper), .sysFailEvt(sysFailEvt), .acFailEvt(acFailEvt),
    .abortEvt(abortEvt), .wdService(wdService), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .nmiWrEn(nmiWrEn), .nmiWrData(nmiWrData),
    .status1(status1), .status2(status2), .auxIntStat(auxIntStat),
    .irqOut(irqOut), .nmiOut(nmiOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctrlWrite(input logic [7:0] d);
    ctrlWrEn = 1; ctrlWrData = d; cyc(1); ctrlWrEn = 0;
  endtask

  task automatic nmiWrite(input logic [7:0] d);
    nmiWrEn = 1; nmiWrData = d; cyc(1); nmiWrEn = 0;
  endtask

  task automatic dpRead(input logic [AW-1:0] a);
    dpRdStb = 1; dpAddr = a; cyc(1); dpRdStb = 0;
  endtask

  task automatic testReset;
    chk("R1 status1", status1, 8'h00);
    chk("R1 status2", status2, 8'h80);
    chk("R1 auxIntStat", auxIntStat, 8'h00);
    chk("R1 irqOut", {7'b0, irqOut}, 8'h00);
    chk("R1 nmiOut", {7'b0, nmiOut}, 8'h00);
  endtask

  task automatic testDualPort;
    ctrlWrite(8'h80);
    dpRead(16);
    chk("R3 addr 16 ignored", auxIntStat, 8'h00);
    dpIrqJumper = 0; dpRead(3); dpIrqJumper = 1;
    chk("R3 jumper off ignored", auxIntStat, 8'h00);
    dpRead(15);
    chk("R2 addr 15 sets", auxIntStat, 8'h01);
    chk("R2 irqOut", {7'b0, irqOut}, 8'h01);
    ctrlWrite(8'h80);
    chk("R4 bit7=1 keeps", auxIntStat, 8'h01);
    ctrlWrite(8'h00);
    chk("R4 bit7=0 clears", auxIntStat, 8'h00);
    ctrlWrite(8'h80);
    dpRead(0);
    chk("R2 addr 0 sets", {7'b0, irqOut}, 8'h01);
    dpRdStb = 1; dpAddr = 5; ctrlWrEn = 1; ctrlWrData = 8'h00; cyc(1);
    dpRdStb = 0; ctrlWrEn = 0;
    chk("R4 clear wins", auxIntStat, 8'h00);
  endtask

  task automatic testFail;
    ctrlWrite(8'h00);
    acFailEvt = 1; sysFailEvt = 1; abortEvt = 1; cyc(1);
    acFailEvt = 0; sysFailEvt = 0; abortEvt = 0;
    chk("R5 disabled ignores", status1, 8'h00);
    ctrlWrite(8'h10);
    acFailEvt = 1; cyc(1); acFailEvt = 0;
    chk("R5 ac bit1", status1, 8'h02);
    sysFailEvt = 1; cyc(1); sysFailEvt = 0;
    chk("R5 sys bit2", status1, 8'h06);
    abortEvt = 1; cyc(1); abortEvt = 0;
    chk("R5 abort bit3", status1, 8'h0E);
    chk("R9 masked at reset", {7'b0, nmiOut}, 8'h00);
    nmiWrite(8'h00);
    chk("R9 enabled", {7'b0, nmiOut}, 8'h01);
    nmiWrite(8'h80);
    chk("R9 disabled", {7'b0, nmiOut}, 8'h00);
    nmiWrite(8'h7F);
    chk("R9 bit7=0 enables", {7'b0, nmiOut}, 8'h01);
    ctrlWrite(8'h00);
    chk("R6 clear all", status1, 8'h00);
    chk("R9 no latch no nmi", {7'b0, nmiOut}, 8'h00);
    ctrlWrite(8'h80); dpRead(1);
    chk("R9 dp not nmi", {7'b0, nmiOut}, 8'h00);
    ctrlWrite(8'h00);
  endtask

  task automatic testWatchdog;
    ctrlWrite(8'h01);
    cyc(WD - 1);
    chk("R7 edge before expiry", status2, 8'h80);
    cyc(1);
    chk("R7 expiry", status2, 8'h00);
    chk("R9 wd drives nmi", {7'b0, nmiOut}, 8'h01);
    cyc(5);
    chk("R8 stays set", status2, 8'h00);
    ctrlWrite(8'h00);
    chk("R8 bit0=0 clears", status2, 8'h80);
    ctrlWrite(8'h01);
    cyc(9);
    wdService = 1; cyc(1); wdService = 0;
    cyc(WD - 1);
    chk("R7 service restarts", status2, 8'h80);
    cyc(1);
    chk("R7 expiry after service", status2, 8'h00);
    chk("R8 low bits zero", status2 & 8'h7F, 8'h00);
    ctrlWrite(8'h00);
  endtask

  initial begin
    fork
      begin
        cyc(3); rstN = 1; cyc(1);
        testReset();
        testDualPort();
        testFail();
        testWatchdog();
      end
      begin
        cyc(5000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule